// File: doc/BRIEF.md
# Auxiliary Memory Bank Decoder

This block sits between the CPU bus of an 8-bit micro and its memory arrays. For every bus cycle it turns the 16-bit CPU address into a physical target and a physical offset, and it does so twice: once for the read path and once for the write path. The two paths can resolve to different banks for the same address. The possible targets are the main RAM bank, the auxiliary RAM bank, internal ROM and peripheral-card ROM. The upper region starting at D000 is tagged for a separate bank-switching unit, and the I/O page C000-C0FF is tagged as no target.

The mode flags arrive as plain level inputs from a soft-switch block. On each cycle in which the bus strobe is high, the decoder samples the address, the write qualifier and the flags. The result appears on registered outputs one clock later, together with a one-cycle valid pulse. Between strobes the outputs hold. A write into the ROM space is flagged with a one-cycle write-ignored pulse, and its write target is forced to no target so that nothing downstream is modified.

Top module: `auxmem_decoder`

## Requirements
- R1: For addresses 0000-01FF, the read and write targets are both auxiliary RAM (code 1) when `zp_aux` is 1, and both main RAM (code 0) when it is 0. For every RAM target the offset equals the CPU address.
- R2: For 0200-BFFF outside the text window, or inside it with `text_store` at 0, the read target is auxiliary RAM when `rd_aux` is 1 and main RAM otherwise. The write target follows `wr_aux` in the same way, independently of the read target.
- R3: When `text_store` is 1, addresses 0400-07FF go to auxiliary RAM for both paths if `text_page2` is 1, and to main RAM for both paths if it is 0. In this case `rd_aux` and `wr_aux` are ignored.
- R4: When `text_store` is 0, the text window 0400-07FF follows `rd_aux` and `wr_aux` as in R2, and `text_page2` has no effect there.
- R5: The hi-res window 2000-3FFF follows only `rd_aux` and `wr_aux`. `text_page2` has no effect there, even when `text_store` is 1.
- R6: Reads from C100-CFFF, apart from C300-C3FF and C600-C6FF, target internal ROM (code 2) with offset equal to address bits 11:0. The write target for the whole of C100-CFFF is no target (code 7) with offset 0.
- R7: Reads from C300-C3FF target internal ROM when `c3_internal` is 1 and card ROM (code 3) when it is 0. In both cases the offset is address bits 11:0.
- R8: Reads from C600-C6FF target card ROM when `cx_card` is 1 and internal ROM when it is 0. In both cases the offset is address bits 11:0.
- R9: A strobed write (`bus_we` 1) to C100-CFFF raises `wr_ignored` for exactly the one cycle in which its result is presented. A write to any other address leaves `wr_ignored` at 0.
- R10: The outputs update on the clock edge that samples a high `bus_strobe` and hold otherwise. `out_valid` is 1 only in the cycle after a strobe. Under synchronous reset both targets are main RAM, both offsets are 0, and `out_valid` and `wr_ignored` are 0.
- R11: Addresses D000-FFFF give pass-through (code 4) on both paths with offset equal to the address. Addresses C000-C0FF give no target (code 7) with offset 0 on both paths.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_strobe | input | 1 | Bus cycle valid; sample address and flags |
| bus_addr | input | 16 | CPU address |
| bus_we | input | 1 | Cycle is a write |
| zp_aux | input | 1 | Zero page and stack to auxiliary RAM |
| rd_aux | input | 1 | Reads of general RAM to auxiliary RAM |
| wr_aux | input | 1 | Writes of general RAM to auxiliary RAM |
| text_store | input | 1 | Text window controlled by page select |
| text_page2 | input | 1 | Page select for the text window |
| c3_internal | input | 1 | C3xx reads from internal ROM |
| cx_card | input | 1 | C6xx reads from card ROM |
| out_valid | output | 1 | Result of a strobed cycle is present |
| rd_tgt | output | 3 | Read target code |
| rd_off | output | 16 | Read physical offset |
| wr_tgt | output | 3 | Write target code |
| wr_off | output | 16 | Write physical offset |
| wr_ignored | output | 1 | Strobed write hit ROM space |

## Verification
Two functions can act on one strobe: the text-window override from the page select, and the independent read and write bank selects. Vectors put the text window under `text_store` together with `rd_aux` and `wr_aux` values that would split the paths, and expect both paths to follow `text_page2` alone. A second case collides the write-ignored pulse with a card-ROM read on the same C6xx write. There, the read must still report card ROM while the write reports no target and `wr_ignored` is high.

// File: rtl/auxmem_pkg.sv
package auxmem_pkg;

    localparam int ADDR_W = 16;
    localparam int TGT_W  = 3;
    localparam int ROMOFF_W = 12;

    typedef enum logic [TGT_W-1:0] {
        TGT_MAIN  = 3'd0,
        TGT_AUX   = 3'd1,
        TGT_IROM  = 3'd2,
        TGT_CROM  = 3'd3,
        TGT_PASS  = 3'd4,
        TGT_NONE  = 3'd7
    } target_e;

    typedef enum logic [3:0] {
        RG_ZP,
        RG_TEXT,
        RG_HIRES,
        RG_GEN,
        RG_IO,
        RG_IROM,
        RG_C3,
        RG_C6,
        RG_UPPER
    } region_e;

    typedef struct packed {
        logic zp_aux;
        logic rd_aux;
        logic wr_aux;
        logic text_store;
        logic text_page2;
        logic c3_internal;
        logic cx_card;
    } mode_flags_t;

    typedef struct packed {
        target_e             tgt;
        logic [ADDR_W-1:0]   off;
    } route_t;

    function automatic logic [ADDR_W-1:0] phys_offset(input target_e t,
                                                      input logic [ADDR_W-1:0] a);
        logic [ADDR_W-1:0] o;
        case (t)
            TGT_IROM, TGT_CROM: o = {{(ADDR_W-ROMOFF_W){1'b0}}, a[ROMOFF_W-1:0]};
            TGT_NONE:           o = '0;
            default:            o = a;
        endcase
        return o;
    endfunction

endpackage

// File: rtl/auxmem_region_decode.sv
module auxmem_region_decode
    import auxmem_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    output region_e           region
);
    always_comb begin
        if (addr < 16'h0200)                          region = RG_ZP;
        else if (addr >= 16'h0400 && addr < 16'h0800) region = RG_TEXT;
        else if (addr >= 16'h2000 && addr < 16'h4000) region = RG_HIRES;
        else if (addr < 16'hC000)                     region = RG_GEN;
        else if (addr < 16'hC100)                     region = RG_IO;
        else if (addr[15:8] == 8'hC3)                 region = RG_C3;
        else if (addr[15:8] == 8'hC6)                 region = RG_C6;
        else if (addr < 16'hD000)                     region = RG_IROM;
        else                                          region = RG_UPPER;
    end
endmodule

// File: rtl/auxmem_path_select.sv
module auxmem_path_select
    import auxmem_pkg::*;
#(
    parameter bit IS_WRITE = 1'b0
) (
    input  region_e           region,
    input  mode_flags_t       flags,
    input  logic [ADDR_W-1:0] addr,
    output route_t            route
);
    logic    ram_aux;
    target_e t;

    assign ram_aux = IS_WRITE ? flags.wr_aux : flags.rd_aux;

    always_comb begin
        case (region)
            RG_ZP:    t = flags.zp_aux ? TGT_AUX : TGT_MAIN;
            RG_TEXT:  t = flags.text_store ? (flags.text_page2 ? TGT_AUX : TGT_MAIN)
                                           : (ram_aux ? TGT_AUX : TGT_MAIN);
            RG_HIRES,
            RG_GEN:   t = ram_aux ? TGT_AUX : TGT_MAIN;
            RG_IO:    t = TGT_NONE;
            RG_IROM:  t = IS_WRITE ? TGT_NONE : TGT_IROM;
            RG_C3:    t = IS_WRITE ? TGT_NONE : (flags.c3_internal ? TGT_IROM : TGT_CROM);
            RG_C6:    t = IS_WRITE ? TGT_NONE : (flags.cx_card ? TGT_CROM : TGT_IROM);
            RG_UPPER: t = TGT_PASS;
            default:  t = TGT_NONE;
        endcase
        route.tgt = t;
        route.off = phys_offset(t, addr);
    end
endmodule

// File: rtl/auxmem_decoder.sv
module auxmem_decoder
    import auxmem_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_strobe,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic              zp_aux,
    input  logic              rd_aux,
    input  logic              wr_aux,
    input  logic              text_store,
    input  logic              text_page2,
    input  logic              c3_internal,
    input  logic              cx_card,
    output logic              out_valid,
    output logic [TGT_W-1:0]  rd_tgt,
    output logic [ADDR_W-1:0] rd_off,
    output logic [TGT_W-1:0]  wr_tgt,
    output logic [ADDR_W-1:0] wr_off,
    output logic              wr_ignored
);
    localparam int NPATH = 2;

    mode_flags_t flags;
    region_e     region;
    route_t      route_c [NPATH];
    route_t      route_q [NPATH];
    logic        rom_space;

    assign flags = '{zp_aux: zp_aux, rd_aux: rd_aux, wr_aux: wr_aux,
                     text_store: text_store, text_page2: text_page2,
                     c3_internal: c3_internal, cx_card: cx_card};

    auxmem_region_decode u_region (
        .addr   (bus_addr),
        .region (region)
    );

    for (genvar p = 0; p < NPATH; p++) begin : g_path
        auxmem_path_select #(.IS_WRITE(p == 1)) u_sel (
            .region (region),
            .flags  (flags),
            .addr   (bus_addr),
            .route  (route_c[p])
        );
    end

    assign rom_space = (region == RG_IROM) || (region == RG_C3) || (region == RG_C6);

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int p = 0; p < NPATH; p++) begin
                route_q[p] <= '{tgt: TGT_MAIN, off: '0};
            end
            out_valid  <= 1'b0;
            wr_ignored <= 1'b0;
        end else begin
            out_valid  <= bus_strobe;
            wr_ignored <= bus_strobe && bus_we && rom_space;
            if (bus_strobe) begin
                for (int p = 0; p < NPATH; p++) begin
                    route_q[p] <= route_c[p];
                end
            end
        end
    end

    assign rd_tgt = route_q[0].tgt;
    assign rd_off = route_q[0].off;
    assign wr_tgt = route_q[1].tgt;
    assign wr_off = route_q[1].off;

    // R1: zero page follows zp_aux on both paths
    a_r1_zp_both_paths: assert property (@(posedge clk) disable iff (rst)
        (bus_strobe && bus_addr < 16'h0200) |=>
        (rd_tgt == ($past(zp_aux) ? TGT_AUX : TGT_MAIN)) && (wr_tgt == rd_tgt));

    // R3: text window under page control gives one bank for both paths
    a_r3_text_store_same: assert property (@(posedge clk) disable iff (rst)
        (bus_strobe && text_store && bus_addr >= 16'h0400 && bus_addr < 16'h0800) |=>
        (rd_tgt == wr_tgt) && (rd_tgt == ($past(text_page2) ? TGT_AUX : TGT_MAIN)));

    // R6: ROM space is never a write target
    a_r6_rom_not_writable: assert property (@(posedge clk) disable iff (rst)
        (bus_strobe && bus_addr >= 16'hC100 && bus_addr < 16'hD000) |=>
        (wr_tgt == TGT_NONE) && (wr_off == '0));

    // R9: ignored write only with a no-target write path and a valid cycle
    a_r9_ignored_consistent: assert property (@(posedge clk) disable iff (rst)
        wr_ignored |-> (out_valid && wr_tgt == TGT_NONE && rd_tgt != TGT_NONE));

    // R10: valid follows the strobe by one cycle
    a_r10_valid_after_strobe: assert property (@(posedge clk) disable iff (rst)
        bus_strobe |=> out_valid);

    // R10: outputs hold when no strobe
    a_r10_hold_idle: assert property (@(posedge clk) disable iff (rst)
        !bus_strobe |=> (!out_valid && !wr_ignored && $stable(rd_tgt) && $stable(rd_off)
                         && $stable(wr_tgt) && $stable(wr_off)));

    // R11: upper region passes through
    a_r11_upper_pass: assert property (@(posedge clk) disable iff (rst)
        (bus_strobe && bus_addr >= 16'hD000) |=>
        (rd_tgt == TGT_PASS) && (wr_tgt == TGT_PASS));

endmodule

// File: tb/auxmem_decoder_tb_top.sv
`timescale 1ns/1ps
module auxmem_decoder_tb_top;

    logic        clk = 1'b0;
    logic        rst;
    logic        bus_strobe;
    logic [15:0] bus_addr;
    logic        bus_we;
    logic [6:0]  fl;
    logic        out_valid, wr_ignored;
    logic [2:0]  rd_tgt, wr_tgt;
    logic [15:0] rd_off, wr_off;

    int n_tests = 0;
    int n_fail  = 0;

    always #2.5 clk = ~clk;

    auxmem_decoder dut_i (
        .clk(clk), .rst(rst), .bus_strobe(bus_strobe), .bus_addr(bus_addr), .bus_we(bus_we),
        .zp_aux(fl[6]), .rd_aux(fl[5]), .wr_aux(fl[4]), .text_store(fl[3]),
        .text_page2(fl[2]), .c3_internal(fl[1]), .cx_card(fl[0]),
        .out_valid(out_valid), .rd_tgt(rd_tgt), .rd_off(rd_off),
        .wr_tgt(wr_tgt), .wr_off(wr_off), .wr_ignored(wr_ignored)
    );

    // flags bits: 6 zp_aux,5 rd_aux,4 wr_aux,3 text_store,2 text_page2,1 c3_internal,0 cx_card
    // {addr, we, flags, rd_tgt, rd_off, wr_tgt, wr_off, ignored}
    localparam int NV = 20;
    localparam logic [62:0] VEC [NV] = '{
        {16'h0100,1'b0,7'h00,3'd0,16'h0100,3'd0,16'h0100,1'b0}, // R1
        {16'h01FF,1'b0,7'h40,3'd1,16'h01FF,3'd1,16'h01FF,1'b0}, // R1
        {16'h0200,1'b0,7'h40,3'd0,16'h0200,3'd0,16'h0200,1'b0}, // R2 boundary
        {16'h1234,1'b0,7'h20,3'd1,16'h1234,3'd0,16'h1234,1'b0}, // R2
        {16'hBFFF,1'b0,7'h10,3'd0,16'hBFFF,3'd1,16'hBFFF,1'b0}, // R2
        {16'h0400,1'b0,7'h0C,3'd1,16'h0400,3'd1,16'h0400,1'b0}, // R3
        {16'h07FF,1'b0,7'h38,3'd0,16'h07FF,3'd0,16'h07FF,1'b0}, // R3
        {16'h0500,1'b0,7'h24,3'd1,16'h0500,3'd0,16'h0500,1'b0}, // R4
        {16'h2000,1'b0,7'h0C,3'd0,16'h2000,3'd0,16'h2000,1'b0}, // R5
        {16'h3FFF,1'b0,7'h1C,3'd0,16'h3FFF,3'd1,16'h3FFF,1'b0}, // R5
        {16'hC100,1'b1,7'h00,3'd2,16'h0100,3'd7,16'h0000,1'b1}, // R6 R9
        {16'hC3AB,1'b0,7'h02,3'd2,16'h03AB,3'd7,16'h0000,1'b0}, // R7
        {16'hC3AB,1'b0,7'h00,3'd3,16'h03AB,3'd7,16'h0000,1'b0}, // R7
        {16'hC6EE,1'b0,7'h01,3'd3,16'h06EE,3'd7,16'h0000,1'b0}, // R8
        {16'hC6EE,1'b0,7'h00,3'd2,16'h06EE,3'd7,16'h0000,1'b0}, // R8
        {16'hCFFF,1'b0,7'h00,3'd2,16'h0FFF,3'd7,16'h0000,1'b0}, // R6
        {16'hD000,1'b1,7'h7F,3'd4,16'hD000,3'd4,16'hD000,1'b0}, // R11 R9
        {16'hC050,1'b0,7'h00,3'd7,16'h0000,3'd7,16'h0000,1'b0}, // R11
        {16'h0400,1'b1,7'h0C,3'd1,16'h0400,3'd1,16'h0400,1'b0}, // R3 R9
        {16'hC600,1'b1,7'h01,3'd3,16'h0600,3'd7,16'h0000,1'b1}  // R8 R9
    };

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // drive on a falling edge, result is checked on the falling edge after the capture edge
    task automatic strobe_cycle(input logic [15:0] a, input logic we, input logic [6:0] f);
        bus_addr = a; bus_we = we; fl = f; bus_strobe = 1'b1;
        @(negedge clk);
        bus_strobe = 1'b0;
    endtask

    initial begin
        #200000;
        n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        rst = 1'b1; bus_strobe = 1'b0; bus_addr = 16'h1234; bus_we = 1'b0; fl = 7'h7F;
        repeat (3) @(negedge clk);
        // R10 reset state
        check("R10 reset rd_tgt", 64'(rd_tgt), 64'd0);
        check("R10 reset wr_tgt", 64'(wr_tgt), 64'd0);
        check("R10 reset offs", {32'd0, rd_off, wr_off}, 64'd0);
        check("R10 reset valid/ignored", {62'd0, out_valid, wr_ignored}, 64'd0);
        rst = 1'b0;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            strobe_cycle(VEC[i][62:47], VEC[i][46], VEC[i][45:39]);
            check($sformatf("R1-11 vec%0d valid", i), 64'(out_valid), 64'd1);
            check($sformatf("vec%0d route (R1 R2 R3 R4 R5 R6 R7 R8 R11)", i),
                  {25'd0, rd_tgt, rd_off, wr_tgt, wr_off}, {25'd0, VEC[i][38:1]});
            check($sformatf("R9 vec%0d ignored", i), 64'(wr_ignored), 64'(VEC[i][0]));
        end

        // R10: idle cycles hold outputs and drop the pulses, flag changes ignored
        bus_addr = 16'h0000; fl = 7'h40; bus_we = 1'b1;
        @(negedge clk);
        check("R10 valid drops", 64'(out_valid), 64'd0);
        check("R9 ignored one cycle", 64'(wr_ignored), 64'd0);
        check("R10 hold", {25'd0, rd_tgt, rd_off, wr_tgt, wr_off},
              {25'd0, 3'd3, 16'h0600, 3'd7, 16'h0000});

        // R2: both split directions at a general address
        strobe_cycle(16'h8000, 1'b0, 7'h30);
        check("R2 both aux", {58'd0, rd_tgt, wr_tgt}, {58'd0, 3'd1, 3'd1});
        // R4: page2 ignored without text_store
        strobe_cycle(16'h0600, 1'b0, 7'h04);
        check("R4 page2 no effect", {58'd0, rd_tgt, wr_tgt}, {58'd0, 3'd0, 3'd0});
        // R9: write to general RAM not ignored
        strobe_cycle(16'h0800, 1'b1, 7'h10);
        check("R9 ram write", {61'd0, wr_ignored, wr_tgt}, {61'd0, 1'b0, 3'd1});

        // R10: reset mid-run returns to defaults
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R10 re-reset", {25'd0, rd_tgt, rd_off, wr_tgt, wr_off, out_valid}, 64'd0);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule